// File: doc/BRIEF.md
# Adapter Interrupt Suppression Unit

This unit sits in front of a queued interrupt controller and decides whether adapter interrupt requests for eight interruption classes may pass. For each class it holds a small state machine with three states: `CLS_ALL` (every request passes), `CLS_SINGLE` (armed: the next suppressible request passes and then silences the class) and `CLS_MUTED` (suppressible requests are thrown away). Requests that are not marked suppressible always pass and never move a state machine.

Software-side logic selects the behaviour of one class at a time through the mode-set port. Code 0 moves the class to `CLS_ALL`; code 1 moves it to `CLS_SINGLE`, which also re-arms a muted class. Every other code is refused with a one-cycle error pulse and leaves all classes untouched. The transitions are: any state to `CLS_ALL` on code 0, any state to `CLS_SINGLE` on code 1, `CLS_SINGLE` to `CLS_MUTED` on a suppressible request that is emitted, and hold in every other case. A mode write takes priority over that arming step when both hit one class in the same cycle.

A request that passes produces, one cycle later, a one-cycle valid strobe with a 32-bit I/O interrupt word: bit 31 is the adapter-interrupt indicator, bits 29:27 carry the class, and all other bits are zero.

Top module: `adapter_irq_suppressor`

## Requirements
- R1: After reset every class is in `CLS_ALL`, `irq_valid` and `mode_err` are low.
- R2: Mode code 0 puts the class in `CLS_ALL`; suppressible requests to it are then emitted every time.
- R3: Mode code 1 puts the class in `CLS_SINGLE`; exactly one suppressible request is emitted after it, the following ones are dropped.
- R4: A mode code other than 0 or 1 raises `mode_err` for exactly one cycle, in the cycle after the write, and changes no class state.
- R5: A suppressible request emitted in a class in `CLS_SINGLE` moves that class to `CLS_MUTED`.
- R6: A suppressible request to a class in `CLS_MUTED` produces no `irq_valid` strobe.
- R7: A non-suppressible request is emitted in every state and leaves the class state unchanged.
- R8: The emitted word has bit 31 set, the class in bits 29:27, and all other bits zero.
- R9: `irq_valid` rises exactly one cycle after an accepted request and lasts one cycle per request.
- R10: Mode writes and arming in one class do not change the behaviour of any other class.
- R11: When a mode write and a request hit the same class in one cycle, the request is judged on the old state and the mode write alone sets the new state.
- R12: Writing code 1 to a class in `CLS_MUTED` re-arms it so the next suppressible request is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_valid | input | 1 | Mode write strobe |
| mode_class | input | 3 | Class addressed by the mode write |
| mode_code | input | 16 | Mode code: 0 all, 1 single, others invalid |
| mode_err | output | 1 | One-cycle pulse for an invalid mode code |
| req_valid | input | 1 | Adapter interrupt request strobe |
| req_class | input | 3 | Class of the request |
| req_supp | input | 1 | Request may be suppressed |
| irq_valid | output | 1 | One-cycle strobe: interrupt word is valid |
| irq_word | output | 32 | I/O interrupt word toward the queue |

## Verification
A class stuck in or wrongly entering `CLS_MUTED` shows as a missing or extra `irq_valid` strobe on the very next suppressible request to that class, one cycle after it is presented. A state machine that fails to arm shows on the second suppressible request after a code 1 write, which is then emitted instead of dropped. A mode write that leaks into another class, or an invalid code that alters state, appears only when that class is next requested, so the tests probe every affected class right after each write.

// File: rtl/asu_pkg.sv
package asu_pkg;
    localparam int WORD_W    = 32;
    localparam int IND_BIT   = 31;
    localparam int CLS_LSB   = 27;
    localparam int MODE_W    = 16;

    localparam logic [MODE_W-1:0] MODE_ALL    = 16'd0;
    localparam logic [MODE_W-1:0] MODE_SINGLE = 16'd1;

    typedef enum logic [1:0] {
        CLS_ALL    = 2'd0,
        CLS_SINGLE = 2'd1,
        CLS_MUTED  = 2'd2
    } cls_state_e;
endpackage

// File: rtl/asu_class_fsm.sv
module asu_class_fsm
    import asu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_wr,
    input  logic mode_single,
    input  logic req_hit,
    input  logic req_supp,
    output logic drop
);
    cls_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CLS_ALL;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (mode_wr) begin
            state_nx = mode_single ? CLS_SINGLE : CLS_ALL;
        end else if (req_hit && req_supp) begin
            unique case (state)
                CLS_ALL:    state_nx = CLS_ALL;
                CLS_SINGLE: state_nx = CLS_MUTED;
                CLS_MUTED:  state_nx = CLS_MUTED;
                default:    state_nx = CLS_ALL;
            endcase
        end
    end

    always_comb begin
        drop = 1'b0;
        unique case (state)
            CLS_ALL:    drop = 1'b0;
            CLS_SINGLE: drop = 1'b0;
            CLS_MUTED:  drop = req_hit && req_supp;
            default:    drop = 1'b0;
        endcase
    end

    AST_SINGLE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CLS_SINGLE && req_hit && req_supp && !mode_wr) |=> (state == CLS_MUTED)); // R5
    AST_NONSUPP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hit && !req_supp && !mode_wr) |=> $stable(state)); // R7
    AST_MUTED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CLS_MUTED && !mode_wr) |=> (state == CLS_MUTED)); // R6
endmodule

// File: rtl/asu_word_reg.sv
module asu_word_reg
    import asu_pkg::*;
#(
    parameter int CLS_W = 3
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [CLS_W-1:0]  cls,
    output logic              irq_valid,
    output logic [WORD_W-1:0] irq_word
);
    logic [WORD_W-1:0] word_nx;

    always_comb begin
        word_nx = '0;
        word_nx[IND_BIT] = 1'b1;
        word_nx[CLS_LSB +: CLS_W] = cls;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_word  <= '0;
        end else begin
            irq_valid <= fire;
            irq_word  <= fire ? word_nx : '0;
        end
    end

    AST_WORD_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_word[IND_BIT] && irq_word[CLS_LSB-1:0] == '0)); // R8
endmodule

// File: rtl/adapter_irq_suppressor.sv
module adapter_irq_suppressor
    import asu_pkg::*;
#(
    parameter int NUM_CLASSES = 8
)(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           mode_valid,
    input  logic [$clog2(NUM_CLASSES)-1:0] mode_class,
    input  logic [MODE_W-1:0]              mode_code,
    output logic                           mode_err,
    input  logic                           req_valid,
    input  logic [$clog2(NUM_CLASSES)-1:0] req_class,
    input  logic                           req_supp,
    output logic                           irq_valid,
    output logic [WORD_W-1:0]              irq_word
);
    localparam int CLS_W = $clog2(NUM_CLASSES);

    logic                   code_ok;
    logic                   code_single;
    logic [NUM_CLASSES-1:0] drop_vec;
    logic                   fire;

    always_comb begin
        code_ok     = (mode_code == MODE_ALL) || (mode_code == MODE_SINGLE);
        code_single = (mode_code == MODE_SINGLE);
    end

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        asu_class_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode_wr    (mode_valid && code_ok && (mode_class == CLS_W'(c))),
            .mode_single(code_single),
            .req_hit    (req_valid && (req_class == CLS_W'(c))),
            .req_supp   (req_supp),
            .drop       (drop_vec[c])
        );
    end

    assign fire = req_valid && !(|drop_vec);

    always_ff @(posedge clk) begin
        if (!rst_n) mode_err <= 1'b0;
        else        mode_err <= mode_valid && !code_ok;
    end

    asu_word_reg #(.CLS_W(CLS_W)) u_word (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .cls      (req_class),
        .irq_valid(irq_valid),
        .irq_word (irq_word)
    );

    AST_NONSUPP_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_supp) |=> irq_valid); // R7
    AST_EMIT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> $past(req_valid)); // R9
    AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> $past(mode_valid)); // R4
    AST_DROP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drop_vec)); // R10
endmodule

// File: tb/adapter_irq_suppressor_bench.sv
module adapter_irq_suppressor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_valid = 1'b0;
    logic [2:0]  mode_class = '0;
    logic [15:0] mode_code = '0;
    logic        mode_err;
    logic        req_valid = 1'b0;
    logic [2:0]  req_class = '0;
    logic        req_supp = 1'b0;
    logic        irq_valid;
    logic [31:0] irq_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adapter_irq_suppressor u_adapter_irq_suppressor (
        .clk(clk), .rst_n(rst_n),
        .mode_valid(mode_valid), .mode_class(mode_class), .mode_code(mode_code),
        .mode_err(mode_err),
        .req_valid(req_valid), .req_class(req_class), .req_supp(req_supp),
        .irq_valid(irq_valid), .irq_word(irq_word)
    );

    function automatic logic [31:0] exp_word(input logic [2:0] c);
        return 32'h8000_0000 | (32'(c) << 27);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] c, input logic [15:0] code, input bit exp_err, input string req);
        @(negedge clk);
        mode_valid = 1'b1; mode_class = c; mode_code = code;
        @(negedge clk);
        mode_valid = 1'b0;
        check(req, 32'(mode_err), 32'(exp_err));
        @(negedge clk);
        check(req, 32'(mode_err), 32'd0);
    endtask

    task automatic request(input logic [2:0] c, input bit supp, input bit exp_emit, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_class = c; req_supp = supp;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, 32'(irq_valid), 32'(exp_emit));
        if (exp_emit) check("R8", irq_word, exp_word(c));
        @(negedge clk);
        check("R9", 32'(irq_valid), 32'd0);
    endtask

    task automatic t_reset;
        check("R1", 32'(irq_valid), 32'd0);
        check("R1", 32'(mode_err), 32'd0);
        for (int c = 0; c < 8; c++) request(3'(c), 1'b1, 1'b1, "R1");
    endtask

    task automatic t_all_mode;
        set_mode(3'd2, 16'd0, 1'b0, "R2");
        request(3'd2, 1'b1, 1'b1, "R2");
        request(3'd2, 1'b1, 1'b1, "R2");
        request(3'd2, 1'b1, 1'b1, "R2");
    endtask

    task automatic t_single;
        set_mode(3'd5, 16'd1, 1'b0, "R3");
        request(3'd5, 1'b1, 1'b1, "R3");
        request(3'd5, 1'b1, 1'b0, "R5");
        request(3'd5, 1'b1, 1'b0, "R6");
    endtask

    task automatic t_nonsupp;
        request(3'd5, 1'b0, 1'b1, "R7");
        request(3'd5, 1'b1, 1'b0, "R7");
        set_mode(3'd6, 16'd1, 1'b0, "R7");
        request(3'd6, 1'b0, 1'b1, "R7");
        request(3'd6, 1'b0, 1'b1, "R7");
        request(3'd6, 1'b1, 1'b1, "R7");
        request(3'd6, 1'b1, 1'b0, "R7");
    endtask

    task automatic t_invalid;
        set_mode(3'd5, 16'd2, 1'b1, "R4");
        request(3'd5, 1'b1, 1'b0, "R4");
        set_mode(3'd3, 16'hFFFF, 1'b1, "R4");
        request(3'd3, 1'b1, 1'b1, "R4");
        request(3'd3, 1'b1, 1'b1, "R4");
    endtask

    task automatic t_rearm;
        set_mode(3'd5, 16'd1, 1'b0, "R12");
        request(3'd5, 1'b1, 1'b1, "R12");
        request(3'd5, 1'b1, 1'b0, "R12");
        set_mode(3'd5, 16'd0, 1'b0, "R2");
        request(3'd5, 1'b1, 1'b1, "R2");
    endtask

    task automatic t_independent;
        set_mode(3'd0, 16'd1, 1'b0, "R10");
        request(3'd0, 1'b1, 1'b1, "R10");
        request(3'd1, 1'b1, 1'b1, "R10");
        request(3'd7, 1'b1, 1'b1, "R10");
        request(3'd0, 1'b1, 1'b0, "R10");
    endtask

    task automatic t_collide;
        // class 4 armed; same-cycle request + write of "all"
        set_mode(3'd4, 16'd1, 1'b0, "R11");
        @(negedge clk);
        mode_valid = 1'b1; mode_class = 3'd4; mode_code = 16'd0;
        req_valid = 1'b1; req_class = 3'd4; req_supp = 1'b1;
        @(negedge clk);
        mode_valid = 1'b0; req_valid = 1'b0;
        check("R11", 32'(irq_valid), 32'd1);
        request(3'd4, 1'b1, 1'b1, "R11");
        request(3'd4, 1'b1, 1'b1, "R11");
        // class 4 muted; same-cycle request + write of "single"
        set_mode(3'd4, 16'd1, 1'b0, "R11");
        request(3'd4, 1'b1, 1'b1, "R11");
        @(negedge clk);
        mode_valid = 1'b1; mode_class = 3'd4; mode_code = 16'd1;
        req_valid = 1'b1; req_class = 3'd4; req_supp = 1'b1;
        @(negedge clk);
        mode_valid = 1'b0; req_valid = 1'b0;
        check("R11", 32'(irq_valid), 32'd0);
        request(3'd4, 1'b1, 1'b1, "R11");
        request(3'd4, 1'b1, 1'b0, "R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_all_mode();
        t_single();
        t_nonsupp();
        t_invalid();
        t_rearm();
        t_independent();
        t_collide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule